// File: doc/BRIEF.md
# Quadrature Encoder Up/Down Counter

This block turns the two phase signals of an incremental quadrature encoder into a signed position count. Both phase inputs are asynchronous to the system clock. They pass through a synchronizer chain. The synchronized pair is then compared with its value from the previous clock. Every rising and falling edge of either phase moves a 16-bit counter by one, so the counter advances four times per encoder line. The order in which the phases change sets the direction. One order counts up, the reverse order counts down, and the most recent direction is shown on an output bit.

If both phases change between two successive samples, the step cannot be resolved. The counter keeps its value and a sticky error bit is set. The host can preload the counter to any value, read it at any time, and gate counting with an enable input. The two phase inputs are meant to share pins with the first two capture channels of a timer block. The synchronizer is therefore the only logic that touches the raw pins.

Top module: `quad_step_counter`

## Requirements
- R1: After reset, `count` is 0, `dirUp` is 0 and `errSticky` is 0.
- R2: With the default of two synchronizer stages, a change on the phase pins first shows on `count` after the third rising clock edge that follows it. Two edges after the change, `count` has not yet moved.
- R3: Each phase pair is written as the 2-bit code {phaseA, phaseB}. A move one step forward in the cycle 00, 01, 11, 10, 00 adds one to `count` and sets `dirUp` to 1.
- R4: A move one step backward in that cycle (00, 10, 11, 01, 00) subtracts one from `count` and sets `dirUp` to 0.
- R5: One full period of either phase (four steps in one direction) changes `count` by exactly four.
- R6: A jump of two steps in that cycle (both phases changed between samples) leaves `count` and `dirUp` unchanged and sets `errSticky`. `errSticky` then stays 1 until reset, and later valid steps still count.
- R7: `count` wraps modulo 2^16: one step up from 0xFFFF gives 0x0000, and one step down from 0x0000 gives 0xFFFF.
- R8: While `enable` is 0, steps change neither `count` nor `dirUp` nor `errSticky`. The phase state is still tracked, so the first step after `enable` returns to 1 counts exactly once.
- R9: When `loadEn` is 1 at a clock edge, `count` takes `loadValue` at that edge. This wins over a step decoded in the same cycle, which still updates `dirUp`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Counting enable |
| phaseA | input | 1 | Encoder phase A, asynchronous |
| phaseB | input | 1 | Encoder phase B, asynchronous |
| loadEn | input | 1 | Load `loadValue` into the counter |
| loadValue | input | 16 | Preload value |
| count | output | 16 | Current position count |
| dirUp | output | 1 | Direction of the last valid step, 1 = up |
| errSticky | output | 1 | Set by a two-step jump, cleared only by reset |

## Verification
A wrong stored phase state does not stay hidden. The next pin change decodes as a wrong-sign step or as a two-step jump. Either one shows on `count`, `dirUp` or `errSticky` three edges after that pin change. A wrong synchronizer depth moves that change to the wrong cycle, and the latency checks catch it. Because the bench walks the full cycle both ways and makes every two-step jump from every state, each entry of the decode table is observed at the ports.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  // Strobes sent from the decoder to the counter datapath, one cycle each
  typedef struct packed {
    logic stepUp;
    logic stepDown;
    logic badJump;
  } qdecStrobe_t;
endpackage

// File: rtl/qdec_ctrl.sv
module qdec_ctrl
  import qdec_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        phaseA,
  input  logic        phaseB,
  output qdecStrobe_t strobe
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncA, syncB;
  logic [1:0]    curAB, prevAB;
  logic [1:0]    curPos, prevPos, delta;

  // R2: synchronizer chain, depth chosen by parameter
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncA <= '0;
          syncB <= '0;
        end else begin
          syncA <= phaseA;
          syncB <= phaseB;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncA <= '0;
          syncB <= '0;
        end else begin
          syncA <= {syncA[LAST-1:0], phaseA};
          syncB <= {syncB[LAST-1:0], phaseB};
        end
      end
    end
  endgenerate

  assign curAB = {syncA[LAST], syncB[LAST]};

  // Previous sampled pair; tracked regardless of enable (R8)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevAB <= 2'b00;
    else       prevAB <= curAB;
  end

  // Position of a code in the forward cycle 00,01,11,10
  function automatic logic [1:0] cyclePos(input logic [1:0] code);
    case (code)
      2'b00:   cyclePos = 2'd0;
      2'b01:   cyclePos = 2'd1;
      2'b11:   cyclePos = 2'd2;
      default: cyclePos = 2'd3;
    endcase
  endfunction

  assign curPos  = cyclePos(curAB);
  assign prevPos = cyclePos(prevAB);
  assign delta   = curPos - prevPos;

  // R3, R4, R6: classify the step by distance around the cycle
  always_comb begin
    strobe.stepUp   = (delta == 2'd1);
    strobe.stepDown = (delta == 2'd3);
    strobe.badJump  = (delta == 2'd2);
  end
endmodule

// File: rtl/qdec_dp.sv
module qdec_dp
  import qdec_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  qdecStrobe_t      strobe,
  input  logic             loadEn,
  input  logic [CNT_W-1:0] loadValue,
  output logic [CNT_W-1:0] count,
  output logic             dirUp,
  output logic             errSticky
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // R1, R7, R9: counter with load priority, wraps naturally
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          count <= '0;
    else if (loadEn)                    count <= loadValue;
    else if (enable && strobe.stepUp)   count <= count + ONE;
    else if (enable && strobe.stepDown) count <= count - ONE;
  end

  // R3, R4: direction of the last valid step
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          dirUp <= 1'b0;
    else if (enable && strobe.stepUp)   dirUp <= 1'b1;
    else if (enable && strobe.stepDown) dirUp <= 1'b0;
  end

  // R6: sticky illegal-transition flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         errSticky <= 1'b0;
    else if (enable && strobe.badJump) errSticky <= 1'b1;
  end
endmodule

// File: rtl/quad_step_counter.sv
module quad_step_counter
  import qdec_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             phaseA,
  input  logic             phaseB,
  input  logic             loadEn,
  input  logic [CNT_W-1:0] loadValue,
  output logic [CNT_W-1:0] count,
  output logic             dirUp,
  output logic             errSticky
);
  qdecStrobe_t strobe;

  qdec_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .phaseA (phaseA),
    .phaseB (phaseB),
    .strobe (strobe)
  );

  qdec_dp #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .strobe    (strobe),
    .loadEn    (loadEn),
    .loadValue (loadValue),
    .count     (count),
    .dirUp     (dirUp),
    .errSticky (errSticky)
  );
endmodule

// File: rtl/qdec_checker.sv
module qdec_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             loadEn,
  input logic [CNT_W-1:0] loadValue,
  input logic [CNT_W-1:0] count,
  input logic             dirUp,
  input logic             errSticky
);
  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> count == $past(loadValue));

  a_r8_disabled_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !loadEn) |=> ($stable(count) && $stable(dirUp) && $stable(errSticky)));

  a_r3_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !loadEn) |=> (count == $past(count)
                             || count == CNT_W'($past(count) + 1'b1)
                             || count == CNT_W'($past(count) - 1'b1)));

  a_r4_dir_matches: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(loadEn) && count != $past(count)) |-> (dirUp == (count == CNT_W'($past(count) + 1'b1))));

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errSticky |=> errSticky);

  a_r6_err_holds_count: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(errSticky) && !$past(loadEn)) |-> ($stable(count) && $stable(dirUp)));
endmodule

bind quad_step_counter qdec_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .loadEn    (loadEn),
  .loadValue (loadValue),
  .count     (count),
  .dirUp     (dirUp),
  .errSticky (errSticky)
);

// File: tb/tb_quad_step_counter.sv
module tb_quad_step_counter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b1;
  logic        phaseA = 1'b0;
  logic        phaseB = 1'b0;
  logic        loadEn = 1'b0;
  logic [15:0] loadValue = '0;
  logic [15:0] count;
  logic        dirUp;
  logic        errSticky;

  int vectors = 0;
  int fails = 0;

  logic [1:0]  curPos = 2'd0;
  logic [15:0] expCount = '0;
  logic        expDir = 1'b0;
  logic        expErr = 1'b0;

  always #10 clk = ~clk;

  quad_step_counter dut (
    .clk(clk), .rstN(rstN), .enable(enable), .phaseA(phaseA), .phaseB(phaseB),
    .loadEn(loadEn), .loadValue(loadValue), .count(count), .dirUp(dirUp),
    .errSticky(errSticky)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Forward-cycle position to pin code: 0->00, 1->01, 2->11, 3->10
  function automatic logic [1:0] posToCode(input logic [1:0] p);
    return {p[1], p[1] ^ p[0]};
  endfunction

  task automatic checkAll(input string req);
    check(req, "count", {16'h0, count}, {16'h0, expCount});
    check(req, "dirUp", {31'h0, dirUp}, {31'h0, expDir});
    check(req, "errSticky", {31'h0, errSticky}, {31'h0, expErr});
  endtask

  task automatic applyPos(input logic [1:0] nextPos, input string req);
    logic [1:0] delta;
    delta = nextPos - curPos;
    if (enable) begin
      if (delta == 2'd1) begin expCount = expCount + 16'd1; expDir = 1'b1; end
      else if (delta == 2'd3) begin expCount = expCount - 16'd1; expDir = 1'b0; end
      else if (delta == 2'd2) expErr = 1'b1;
    end
    if (loadEn) expCount = loadValue;
    curPos = nextPos;
    @(negedge clk);
    {phaseA, phaseB} = posToCode(nextPos);
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkAll(req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    checkAll("R1");
    rstN = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    checkAll("R1");

    // R2: latency of one forward step 00 -> 01
    @(negedge clk);
    {phaseA, phaseB} = 2'b01;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R2", "count before third edge", {16'h0, count}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    check("R2", "count after third edge", {16'h0, count}, 32'h1);
    curPos = 2'd1; expCount = 16'd1; expDir = 1'b1;

    // R3/R5: forward walk, two full periods
    for (int i = 0; i < 8; i++) begin
      applyPos(curPos + 2'd1, "R3");
      if (i == 3) check("R5", "one period up", {16'h0, count}, 32'd5);
    end
    // R4/R7: backward walk through zero
    for (int i = 0; i < 13; i++) applyPos(curPos - 2'd1, "R4");
    check("R7", "wrap below zero", {16'h0, count}, 32'h0000FFFC);

    // R7: wrap above 0xFFFF after a preload
    @(negedge clk);
    loadEn = 1'b1; loadValue = 16'hFFFE;
    @(negedge clk);
    loadEn = 1'b0;
    expCount = 16'hFFFE;
    check("R9", "plain load", {16'h0, count}, 32'h0000FFFE);
    for (int i = 0; i < 3; i++) applyPos(curPos + 2'd1, "R7");
    check("R7", "wrap above max", {16'h0, count}, 32'h1);

    // R8: disabled steps ignored, state still tracked
    @(negedge clk);
    enable = 1'b0;
    applyPos(curPos - 2'd1, "R8");
    applyPos(curPos - 2'd1, "R8");
    applyPos(curPos + 2'd2, "R8");
    @(negedge clk);
    enable = 1'b1;
    applyPos(curPos + 2'd1, "R8");

    // R9: load held across a backward step: load wins, direction follows step
    @(negedge clk);
    loadEn = 1'b1; loadValue = 16'h1234;
    applyPos(curPos - 2'd1, "R9");
    @(negedge clk);
    loadEn = 1'b0;
    applyPos(curPos + 2'd1, "R9");

    // R6: a two-step jump from every state, sticky flag, later steps count
    for (int i = 0; i < 4; i++) begin
      applyPos(curPos + 2'd2, "R6");
      applyPos(curPos + 2'd1, "R6");
    end
    applyPos(curPos - 2'd1, "R6");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule